// File: doc/BRIEF.md
# GPIO with Edge Interrupts

A 32-pin general-purpose I/O block on a small memory-mapped register bus. Each pin can drive its pad through an output value and an output-enable bit. It can also sample the pad through a two-flop synchronizer that is gated by an input-enable bit. Software reads the gated pin levels from a status word and writes the control words directly. Writes complete at the clock edge they are presented on. Read data is a combinational function of the address.

Each pin tracks rising and falling transitions of its synchronized input in two separate sticky pending words. A bit is set on every detected edge of its kind, and writing a 1 to it clears it. Two arm words, one for rising edges and one for falling edges, decide which pending bits reach the pin's own interrupt line. The block therefore drives 32 independent request lines, indexed by pin, toward an external interrupt controller. A line stays high until software clears the pending bit behind it or disarms it.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every register word reads 0, and `pad_oe`, `pad_out` and `irq` are all 0.
- R2: The words at byte offsets 0x04 (input enable), 0x08 (output enable), 0x0C (output value), 0x10 (rising arm) and 0x18 (falling arm) read back the last value written. A write to offset 0x00 has no effect.
- R3: `pad_out` equals the output value word and `pad_oe` equals the output enable word, from the clock edge after the write.
- R4: Offset 0x00 returns `pad_in` delayed by two clock edges, ANDed bit by bit with the input enable word.
- R5: A 0-to-1 change on an input-enabled pin sets its bit in the rising pending word (offset 0x14) on the third clock edge after the pad change, whatever the arm bits hold.
- R6: A 1-to-0 change on an input-enabled pin sets its bit in the falling pending word (offset 0x1C) on the third clock edge after the pad change, whatever the arm bits hold.
- R7: A pin whose input-enable bit is 0 sets no pending bit when its pad changes.
- R8: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. A write never sets a pending bit.
- R9: `irq[n]` is high exactly when (rising pending[n] and rising arm[n]) or (falling pending[n] and falling arm[n]). It stays high after the pad returns to its old level, until the bit is cleared.
- R10: When an edge is detected in the same cycle as a write that clears that pending bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 32 | Per-pin interrupt requests |

## Verification
Edge detection is driven with a sequence of whole-word pad patterns. These include all-low, all-high and low byte set, plus alternating nibble patterns that move both ways at once. Each pattern is paired with a different mix of input enables and arm words. This separates rising edges from falling ones, enabled pins from disabled ones, and pending bits from armed interrupt lines. A single-edge walk confirms when the synchronized level appears. A timed clear that lands on the edge's detection cycle shows whether the new event survives, and a second pending bit cleared in the same write shows that the clear itself still works.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    // word index = byte address bits [4:2]
    typedef enum logic [2:0] {
        WSEL_LEVEL    = 3'd0,
        WSEL_IN_EN    = 3'd1,
        WSEL_OUT_EN   = 3'd2,
        WSEL_OUT_VAL  = 3'd3,
        WSEL_RISE_ARM = 3'd4,
        WSEL_RISE_PND = 3'd5,
        WSEL_FALL_ARM = 3'd6,
        WSEL_FALL_PND = 3'd7
    } wsel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] raw_i,
    output logic [NPIN-1:0] sync_o
);
    typedef struct packed {
        logic [NPIN-1:0] stage1;
        logic [NPIN-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.stage1 = raw_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stage2;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] level_i,
    input  logic [NPIN-1:0] enable_i,
    output logic [NPIN-1:0] rise_o,
    output logic [NPIN-1:0] fall_o
);
    logic [NPIN-1:0] prev_d, prev_q;

    // prev follows the ungated level so toggling enable makes no edge
    always_comb begin
        prev_d = level_i;
        rise_o = level_i & ~prev_q & enable_i;
        fall_o = ~level_i & prev_q & enable_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPIN-1:0]   wdata_i,
    output logic [NPIN-1:0]   rdata_o,
    input  logic [NPIN-1:0]   level_i,
    input  logic [NPIN-1:0]   rise_evt_i,
    input  logic [NPIN-1:0]   fall_evt_i,
    output logic [NPIN-1:0]   in_en_o,
    output logic [NPIN-1:0]   out_en_o,
    output logic [NPIN-1:0]   out_val_o,
    output logic [NPIN-1:0]   rise_arm_o,
    output logic [NPIN-1:0]   fall_arm_o,
    output logic [NPIN-1:0]   rise_pnd_o,
    output logic [NPIN-1:0]   fall_pnd_o
);
    typedef struct packed {
        logic [NPIN-1:0] in_en;
        logic [NPIN-1:0] out_en;
        logic [NPIN-1:0] out_val;
        logic [NPIN-1:0] rise_arm;
        logic [NPIN-1:0] rise_pnd;
        logic [NPIN-1:0] fall_arm;
        logic [NPIN-1:0] fall_pnd;
    } regs_t;

    regs_t rg_d, rg_q;
    wsel_e sel;
    logic [NPIN-1:0] rise_clr, fall_clr;

    assign sel = wsel_e'(addr_i[4:2]);

    always_comb begin
        rg_d     = rg_q;
        rise_clr = '0;
        fall_clr = '0;
        if (wr_i) begin
            unique case (sel)
                WSEL_IN_EN:    rg_d.in_en    = wdata_i;
                WSEL_OUT_EN:   rg_d.out_en   = wdata_i;
                WSEL_OUT_VAL:  rg_d.out_val  = wdata_i;
                WSEL_RISE_ARM: rg_d.rise_arm = wdata_i;
                WSEL_FALL_ARM: rg_d.fall_arm = wdata_i;
                WSEL_RISE_PND: rise_clr      = wdata_i;
                WSEL_FALL_PND: fall_clr      = wdata_i;
                default:       ;
            endcase
        end
        // a fresh edge takes priority over a clear of the same bit
        rg_d.rise_pnd = (rg_q.rise_pnd & ~rise_clr) | rise_evt_i;
        rg_d.fall_pnd = (rg_q.fall_pnd & ~fall_clr) | fall_evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        unique case (sel)
            WSEL_LEVEL:    rdata_o = level_i & rg_q.in_en;
            WSEL_IN_EN:    rdata_o = rg_q.in_en;
            WSEL_OUT_EN:   rdata_o = rg_q.out_en;
            WSEL_OUT_VAL:  rdata_o = rg_q.out_val;
            WSEL_RISE_ARM: rdata_o = rg_q.rise_arm;
            WSEL_RISE_PND: rdata_o = rg_q.rise_pnd;
            WSEL_FALL_ARM: rdata_o = rg_q.fall_arm;
            WSEL_FALL_PND: rdata_o = rg_q.fall_pnd;
            default:       rdata_o = '0;
        endcase
    end

    assign in_en_o    = rg_q.in_en;
    assign out_en_o   = rg_q.out_en;
    assign out_val_o  = rg_q.out_val;
    assign rise_arm_o = rg_q.rise_arm;
    assign fall_arm_o = rg_q.fall_arm;
    assign rise_pnd_o = rg_q.rise_pnd;
    assign fall_pnd_o = rg_q.fall_pnd;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   irq
);
    logic [NPIN-1:0] level_s;
    logic [NPIN-1:0] rise_evt, fall_evt;
    logic [NPIN-1:0] in_en, rise_arm, fall_arm, rise_pnd, fall_pnd;

    gpio_in_sync #(.NPIN(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .sync_o (level_s)
    );

    gpio_edge_det #(.NPIN(NPIN)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (level_s),
        .enable_i (in_en),
        .rise_o   (rise_evt),
        .fall_o   (fall_evt)
    );

    gpio_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .rdata_o    (bus_rdata),
        .level_i    (level_s),
        .rise_evt_i (rise_evt),
        .fall_evt_i (fall_evt),
        .in_en_o    (in_en),
        .out_en_o   (pad_oe),
        .out_val_o  (pad_out),
        .rise_arm_o (rise_arm),
        .fall_arm_o (fall_arm),
        .rise_pnd_o (rise_pnd),
        .fall_pnd_o (fall_pnd)
    );

    assign irq = (rise_pnd & rise_arm) | (fall_pnd & fall_arm);
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPIN-1:0]   bus_wdata,
    input logic [NPIN-1:0]   pad_oe,
    input logic [NPIN-1:0]   irq,
    input logic [NPIN-1:0]   in_en,
    input logic [NPIN-1:0]   rise_evt,
    input logic [NPIN-1:0]   fall_evt,
    input logic [NPIN-1:0]   rise_pnd,
    input logic [NPIN-1:0]   fall_pnd
);
    // R3
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[4:2] == 3'd2) |=> (pad_oe == $past(bus_wdata)));

    // R7
    no_gated_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_evt | fall_evt) & ~in_en) == '0);

    // R8
    pnd_only_by_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((rise_pnd & ~$past(rise_pnd) & ~$past(rise_evt)) |
                   (fall_pnd & ~$past(fall_pnd) & ~$past(fall_evt))) == '0));

    // R10
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise_evt | fall_evt)) |=>
            (((rise_pnd & $past(rise_evt)) == $past(rise_evt)) &&
             ((fall_pnd & $past(fall_evt)) == $past(fall_evt))));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((irq & $past(irq)) == $past(irq)));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .in_en     (in_en),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .rise_pnd  (rise_pnd),
    .fall_pnd  (fall_pnd)
);

// File: tb/test_gpio_edge_irq.sv
`timescale 1ns/1ps
module test_gpio_edge_irq;
    localparam int NPIN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [4:0]      bus_addr = '0;
    logic [NPIN-1:0] bus_wdata = '0;
    logic [NPIN-1:0] bus_rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_out, pad_oe, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    gpio_edge_irq i_gpio_edge_irq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // {pad pattern, input enable, rising arm, falling arm}
    localparam logic [127:0] VEC [6] = '{
        {32'h0000_00FF, 32'hFFFF_FFFF, 32'h0000_000F, 32'h0000_0000},
        {32'h0000_0F0F, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
        {32'hA5A5_A5A5, 32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_FFFF},
        {32'h5A5A_5A5A, 32'hFFFF_0000, 32'h00FF_FF00, 32'hFFFF_FFFF},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'h0000_0000, 32'h8000_0001, 32'h0000_0000, 32'hFFFF_FFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, old_pad, new_pad, ien, rarm, farm, er, ef;
        wait_cyc(3);
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), d);
            check("R1 reset word", d, 32'h0);
        end
        check("R1 irq", irq, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: readback, write to level word ignored
        wr(5'h04, 32'h1234_5678); wr(5'h08, 32'hDEAD_BEEF); wr(5'h0C, 32'hCAFE_F00D);
        wr(5'h10, 32'h0F0F_0F0F); wr(5'h18, 32'hF0F0_F0F0); wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h04, d); check("R2 in_en", d, 32'h1234_5678);
        rd(5'h08, d); check("R2 out_en", d, 32'hDEAD_BEEF);
        rd(5'h0C, d); check("R2 out_val", d, 32'hCAFE_F00D);
        rd(5'h10, d); check("R2 rise_arm", d, 32'h0F0F_0F0F);
        rd(5'h18, d); check("R2 fall_arm", d, 32'hF0F0_F0F0);
        rd(5'h00, d); check("R2 level unchanged", d, 32'h0);
        // R3
        check("R3 pad_oe", pad_oe, 32'hDEAD_BEEF);
        check("R3 pad_out", pad_out, 32'hCAFE_F00D);

        // R4: two-edge latency of level
        wr(5'h04, 32'hFFFF_FFFF);
        @(negedge clk);
        pad_in = 32'h0000_0100;
        @(negedge clk);
        rd(5'h00, d); check("R4 level after one edge", d, 32'h0);
        @(negedge clk);
        rd(5'h00, d); check("R4 level after two edges", d, 32'h0000_0100);
        wr(5'h04, 32'h0000_0000);
        rd(5'h00, d); check("R4 level gated", d, 32'h0);
        pad_in = 32'h0;
        wait_cyc(4);
        wr(5'h14, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF);
        old_pad = 32'h0;

        // table walk: R5 R6 R7 R9
        for (int v = 0; v < 6; v++) begin
            {new_pad, ien, rarm, farm} = VEC[v];
            wr(5'h04, ien); wr(5'h10, rarm); wr(5'h18, farm);
            wr(5'h14, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF);
            pad_in = new_pad;
            wait_cyc(4);
            er = new_pad & ~old_pad & ien;
            ef = ~new_pad & old_pad & ien;
            rd(5'h14, d); check("R5/R7 rise pending", d, er);
            rd(5'h1C, d); check("R6/R7 fall pending", d, ef);
            rd(5'h00, d); check("R4 level", d, new_pad & ien);
            check("R9 irq", irq, (er & rarm) | (ef & farm));
            old_pad = new_pad;
        end
        wr(5'h14, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF);
        check("R8 irq after clear", irq, 32'h0);

        // R9 hold, R8 zero-write, R10 edge vs clear
        wr(5'h04, 32'hFFFF_FFFF); wr(5'h10, 32'h0000_0020); wr(5'h18, 32'h0000_0020);
        pad_in = 32'h0000_0060;
        wait_cyc(4);
        pad_in = 32'h0000_0040;
        wait_cyc(4);
        check("R9 irq held", irq, 32'h0000_0020);
        wr(5'h1C, 32'h0000_0000);
        rd(5'h1C, d); check("R8 zero write keeps", d, 32'h0000_0020);
        wr(5'h1C, 32'h0000_0020);
        rd(5'h1C, d); check("R8 one write clears", d, 32'h0);
        check("R9 irq still from rise", irq, 32'h0000_0020);
        rd(5'h14, d); check("R5 rise pending pins 5 6", d, 32'h0000_0060);
        @(negedge clk);
        pad_in = 32'h0000_0060;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'h14; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(5'h14, d); check("R10 edge beats clear", d, 32'h0000_0020);
        check("R10 irq", irq, 32'h0000_0020);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule